// File: doc/BRIEF.md
# Discharge Rate Classifier with Overload Hold

This block sorts a measured battery discharge rate into one of three regimes. The rate is given as a multiple of battery capacity in steps of C/16. The block registers a 3-bit regime code each time a new rate sample is strobed in. Above 2C it raises an overload flag. The flag sets on the first sample above the limit. Once the rate falls back, it is released only after a fixed hold measured in ticks of an external time base. The nominal hold is half a second, so with a 1 ms tick the parameter is 500.

A sampling-inhibit output follows the overload flag. End-of-discharge voltage sampling downstream uses it to pause while heavy load distorts the terminal voltage. Measuring the rate and comparing the voltage are done by other blocks.

Top module: `rate_class`

## Requirements
- R1: After reset, `rate_code` is 000, `ovld` is 0 and `edv_inhibit` is 0.
- R2: On the clock edge of a cycle with `rate_vld` high and `rate` below LO_TH (8, meaning 0.5C), `rate_code` becomes 000.
- R3: On the clock edge of a cycle with `rate_vld` high and `rate` from LO_TH up to HI_TH inclusive (8 to 32, meaning 0.5C to 2C), `rate_code` becomes 001.
- R4: On the clock edge of a cycle with `rate_vld` high and `rate` above HI_TH (above 32), `rate_code` becomes 010.
- R5: In cycles with `rate_vld` low, `rate_code` holds its value whatever `rate` carries.
- R6: A strobed sample above HI_TH sets `ovld` on that clock edge. `ovld` then stays set, whatever ticks arrive, for as long as no sample at or below HI_TH is strobed.
- R7: After a strobed sample at or below HI_TH follows an over-limit sample, `ovld` clears on the edge that counts the HOLD_TICKS-th tick. Only ticks in later cycles without a strobe are counted; a tick in a strobe cycle is ignored.
- R8: A sample above HI_TH strobed during the hold keeps `ovld` set with no gap. A later drop then needs a full HOLD_TICKS ticks again.
- R9: `edv_inhibit` is high exactly when `ovld` is high.
- R10: While `ovld` is clear, ticks and samples at or below HI_TH leave it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle time-base pulse for the hold |
| rate_vld | input | 1 | Strobe that marks `rate` as a new sample |
| rate | input | RATE_W | Discharge rate in units of C/16 |
| rate_code | output | 3 | Regime: 000 low, 001 mid, 010 high |
| ovld | output | 1 | Overload flag with a timed release |
| edv_inhibit | output | 1 | Blocks end-of-discharge voltage sampling |

## Verification
The bench builds the block with the default 8-bit rate and thresholds and with HOLD_TICKS set to 3. That makes every rate value from 0 to 255 cheap to sweep, so both threshold edges at 8 and 32 are hit exactly. The short hold lets the bench step tick by tick through the whole release window. It also retriggers in the middle of a hold and then checks that the count starts again from the full length.

// File: rtl/rate_class.sv
module rate_class #(
  parameter int RATE_W     = 8,
  parameter int LO_TH      = 8,
  parameter int HI_TH      = 32,
  parameter int HOLD_TICKS = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rate_vld,
  input  logic [RATE_W-1:0] rate,
  output logic [2:0]        rate_code,
  output logic              ovld,
  output logic              edv_inhibit
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [2:0] CODE_LO  = 3'b000;
  localparam logic [2:0] CODE_MID = 3'b001;
  localparam logic [2:0] CODE_HI  = 3'b010;

  logic             over_q;
  logic [CNT_W-1:0] hold_cnt;

  wire is_hi  = rate > RATE_W'(HI_TH);
  wire is_mid = rate >= RATE_W'(LO_TH);

  assign edv_inhibit = ovld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_code <= CODE_LO;
      ovld      <= 1'b0;
      over_q    <= 1'b0;
      hold_cnt  <= '0;
    end else if (rate_vld) begin
      rate_code <= is_hi ? CODE_HI : (is_mid ? CODE_MID : CODE_LO);
      over_q    <= is_hi;
      if (is_hi) begin
        ovld     <= 1'b1;
        hold_cnt <= CNT_W'(HOLD_TICKS);
      end else if (over_q) begin
        hold_cnt <= CNT_W'(HOLD_TICKS);
      end
    end else if (tick && ovld && !over_q) begin
      hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == CNT_W'(1)) ovld <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_class_chk.sv
module rate_class_chk #(
  parameter int RATE_W = 8,
  parameter int LO_TH  = 8,
  parameter int HI_TH  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              rate_vld,
  input logic [RATE_W-1:0] rate,
  input logic [2:0]        rate_code,
  input logic              ovld,
  input logic              edv_inhibit
);
  // R2
  lo_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_vld && rate < RATE_W'(LO_TH) |=> rate_code == 3'b000);
  // R3
  mid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_vld && rate >= RATE_W'(LO_TH) && rate <= RATE_W'(HI_TH) |=> rate_code == 3'b001);
  // R4
  hi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_vld && rate > RATE_W'(HI_TH) |=> rate_code == 3'b010 && ovld);
  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_vld |=> $stable(rate_code));
  // R6
  ovld_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovld && !tick |=> ovld);
  // R10
  ovld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovld && !(rate_vld && rate > RATE_W'(HI_TH)) |=> !ovld);
  // R9
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edv_inhibit == ovld);
endmodule

bind rate_class rate_class_chk #(.RATE_W(RATE_W), .LO_TH(LO_TH), .HI_TH(HI_TH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rate_vld(rate_vld), .rate(rate),
  .rate_code(rate_code), .ovld(ovld), .edv_inhibit(edv_inhibit)
);

// File: tb/sim_rate_class.sv
module sim_rate_class;
  localparam int CLK_P = 10;
  localparam int HOLD  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rate_vld = 1'b0;
  logic [7:0] rate = '0;
  logic [2:0] rate_code;
  logic       ovld, edv_inhibit;
  int n_chk = 0, n_bad = 0;

  rate_class #(.RATE_W(8), .LO_TH(8), .HI_TH(32), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_vld(rate_vld), .rate(rate),
    .rate_code(rate_code), .ovld(ovld), .edv_inhibit(edv_inhibit)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int r, input bit t = 1'b0);
    @(negedge clk); rate_vld = 1'b1; rate = 8'(r); tick = t;
    @(negedge clk); rate_vld = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic int exp_code(input int r);
    return (r > 32) ? 2 : (r >= 8 ? 1 : 0);
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code", rate_code, 0);
    chk("R1 ovld", ovld, 0);
    chk("R1 inhibit", edv_inhibit, 0);
    rst_n = 1'b1;
    // R10: ticks and low samples leave overload clear
    pulse_tick();
    strobe(20);
    pulse_tick();
    chk("R10 ovld idle", ovld, 0);
    // R2 R3 R4 R6: full sweep, ascending
    for (int r = 0; r < 256; r++) begin
      strobe(r);
      chk(r < 8 ? "R2 code" : (r <= 32 ? "R3 code" : "R4 code"), rate_code, exp_code(r));
      chk("R6 ovld sweep", ovld, r > 32 ? 1 : 0);
      chk("R9 inhibit", edv_inhibit, ovld);
    end
    // R5: rate changes without strobe have no effect
    @(negedge clk); rate = 8'd0; @(negedge clk); rate = 8'd16; @(negedge clk);
    chk("R5 code hold", rate_code, 2);
    // R6: ticks while still over do not release
    for (int k = 0; k < HOLD + 2; k++) pulse_tick();
    chk("R6 ovld persists", ovld, 1);
    // R7: drop, tick in the strobe cycle is ignored, then count
    strobe(10, 1'b1);
    chk("R3 code after drop", rate_code, 1);
    for (int k = 1; k <= HOLD; k++) begin
      pulse_tick();
      chk("R7 hold", ovld, k < HOLD ? 1 : 0);
      chk("R9 inhibit hold", edv_inhibit, k < HOLD ? 1 : 0);
    end
    // R8: retrigger during hold
    strobe(100);
    strobe(4);
    chk("R2 code", rate_code, 0);
    pulse_tick();
    chk("R7 mid hold", ovld, 1);
    strobe(40);
    chk("R8 no gap", ovld, 1);
    strobe(32);
    for (int k = 1; k <= HOLD; k++) begin
      pulse_tick();
      chk("R8 full rehold", ovld, k < HOLD ? 1 : 0);
    end
    // R10: after release, more low samples and ticks keep it clear
    strobe(7);
    pulse_tick();
    chk("R10 ovld stays clear", ovld, 0);
    // R1: reset mid-overload
    strobe(200);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 code re-reset", rate_code, 0);
    chk("R1 ovld re-reset", ovld, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule